// File: doc/BRIEF.md
# Pin bank with atomic set/clear registers and edge/level interrupts

This block controls 22 general-purpose pads behind a flat 32-bit register bus. Software drives pad levels through an output data register and turns pad drivers on through an output enable register. Each of these, and the interrupt status register as well, can be written three ways: a plain overwrite, a write-ones-to-set alias and a write-ones-to-clear alias. The aliases let several agents change single bits without a read-modify-write. Pad inputs are brought into the clock domain through a two-flop synchronizer, and a read-only input register returns them.

Each pad has its own configuration word. The word selects a 3-bit trigger mode (rising, falling, either edge, low level, high level or off), a wakeup enable and an open-drain drive mode. Trigger hits latch into the sticky status register. `irq` is high while any status bit is set. `wake` is high while any status bit of a wakeup-enabled pad is set. In open-drain mode a pad is pulled low only when its data bit is 0 and its output is enabled; in every other case the pad is released.

The bus has no handshake. A write takes effect at the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`.

Top module: `sc_gpio_bank`

## Requirements
- R1: While reset is high, and after it, until the first write: all registers read zero, `pad_oe`, `irq` and `wake` are 0, and every pad is in push-pull mode with its trigger off.
- R2: In the data (0x00), enable (0x0C), status (0x18) and input (0x24) words, pad n sits at bit 10+n and bits 9..0 read 0. The configuration word of pad n is at 0x28+4n. Alias addresses and unmapped addresses read 0.
- R3: For data (base 0x00, set 0x04, clear 0x08) and enable (base 0x0C, set 0x10, clear 0x14), a base write overwrites the register, a set write ORs in the write data, and a clear write removes every bit that is 1 in the write data.
- R4: Status has the same three write forms (base 0x18, set 0x1C, clear 0x20). Software can therefore raise status bits, which assert `irq`, and acknowledge them.
- R5: The input word shows a pad change on the second clock edge after the change, and not before.
- R6: Trigger mode 1 latches status on a rising edge of the synchronized input, mode 2 on a falling edge, and mode 3 on either edge. Status stays set after the edge has passed.
- R7: Mode 4 (low) and mode 5 (high) set status on every cycle the level holds. A clear issued while the level holds leaves the bit set.
- R8: Modes 0, 6 and 7 never set status, whatever the pad does.
- R9: When a trigger hit and a clear write meet on the same status bit in the same cycle, the bit ends set.
- R10: `irq` is the OR of all status bits. `wake` is the OR of the status bits whose pad has wakeup enabled.
- R11: In push-pull mode a pad drives `pad_out` equal to its data bit, with `pad_oe` equal to its enable bit. In open-drain mode `pad_out` is 0 and `pad_oe` is 1 only when the data bit is 0 and the enable bit is 1.
- R12: The configuration word holds the open-drain bit at bit 2, the trigger mode at bits 9..7 and the wakeup enable at bit 10. It reads back those fields, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 22 | Asynchronous pad input levels |
| pad_out | output | 22 | Level driven onto each pad |
| pad_oe | output | 22 | Driver enable for each pad |
| irq | output | 1 | Any status bit set |
| wake | output | 1 | Any status bit of a wakeup-enabled pad set |

## Verification
The hardest case to reach from the ports is the collision in R9, where a trigger hit and a software clear land on the same status bit at the same edge. The hit only exists for the single cycle after the synchronized input moves. The stimulus therefore raises the pad at a known falling edge, counts exactly two rising edges, and then holds a clear write across the third edge, where the hit is registered. A status bit that still reads set afterwards shows that the set took priority. The same edge counting is used to show that the input word updates on the second edge after a pad change and not on the first.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W = 32;

    // register byte addresses
    localparam int A_OUT     = 'h00;
    localparam int A_OE      = 'h0C;
    localparam int A_ST      = 'h18;
    localparam int A_IN      = 'h24;
    localparam int A_CFG0    = 'h28;
    localparam int ALIAS_SET = 4;
    localparam int ALIAS_CLR = 8;

    // configuration word fields
    localparam int CFG_OD_BIT   = 2;
    localparam int CFG_MODE_LSB = 7;
    localparam int CFG_WAKE_BIT = 10;

    localparam logic [2:0] TRIG_RISE = 3'd1;
    localparam logic [2:0] TRIG_FALL = 3'd2;
    localparam logic [2:0] TRIG_ANY  = 3'd3;
    localparam logic [2:0] TRIG_LOW  = 3'd4;
    localparam logic [2:0] TRIG_HIGH = 3'd5;

    typedef logic [BUS_W-1:0] word_t;

    typedef struct packed {
        logic       wake;
        logic [2:0] mode;
        logic       od;
    } pin_cfg_t;

    typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_SET, OP_CLR} wr_op_e;

    function automatic logic trig_hit(logic [2:0] mode, logic cur, logic prv);
        case (mode)
            TRIG_RISE: return cur & ~prv;
            TRIG_FALL: return ~cur & prv;
            TRIG_ANY:  return cur ^ prv;
            TRIG_LOW:  return ~cur;
            TRIG_HIGH: return cur;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic wr_op_e decode_op(int addr, int base, logic we);
        if (!we)                         return OP_NONE;
        if (addr == base)                return OP_LOAD;
        if (addr == base + ALIAS_SET)    return OP_SET;
        if (addr == base + ALIAS_CLR)    return OP_CLR;
        return OP_NONE;
    endfunction

    function automatic word_t apply_op(wr_op_e op, word_t cur, word_t wd);
        case (op)
            OP_LOAD: return wd;
            OP_SET:  return cur | wd;
            OP_CLR:  return cur & ~wd;
            default: return cur;
        endcase
    endfunction

    function automatic pin_cfg_t cfg_unpack(word_t w);
        pin_cfg_t c;
        c.od   = w[CFG_OD_BIT];
        c.mode = w[CFG_MODE_LSB +: 3];
        c.wake = w[CFG_WAKE_BIT];
        return c;
    endfunction

    function automatic word_t cfg_pack(pin_cfg_t c);
        word_t w;
        w = '0;
        w[CFG_OD_BIT]        = c.od;
        w[CFG_MODE_LSB +: 3] = c.mode;
        w[CFG_WAKE_BIT]      = c.wake;
        return w;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 22,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [STAGES-1:0][W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            prev_o <= '0;
        end else begin
            sr[0]  <= pad_i;
            for (int s = 1; s < STAGES; s++) sr[s] <= sr[s-1];
            prev_o <= sr[STAGES-1];
        end
    end

    assign sync_o = sr[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_bank_pkg::*;
#(
    parameter int W = 22
) (
    input  logic [W-1:0][2:0] mode_i,
    input  logic [W-1:0]      cur_i,
    input  logic [W-1:0]      prv_i,
    output logic [W-1:0]      evt_o
);
    for (genvar n = 0; n < W; n++) begin : g_pin
        assign evt_o[n] = trig_hit(mode_i[n], cur_i[n], prv_i[n]);
    end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int W = 22
) (
    input  logic [W-1:0] od_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] oe_i,
    output logic [W-1:0] pad_out_o,
    output logic [W-1:0] pad_oe_o
);
    for (genvar n = 0; n < W; n++) begin : g_pin
        assign pad_oe_o[n]  = od_i[n] ? (oe_i[n] & ~data_i[n]) : oe_i[n];
        assign pad_out_o[n] = od_i[n] ? 1'b0 : data_i[n];
    end
endmodule

// File: rtl/sc_gpio_bank.sv
module sc_gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS   = 22,
    parameter int PIN_LSB = 10,
    parameter int AW      = 8,
    parameter int SYNC_FF = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_we,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic               irq,
    output logic               wake
);
    logic [NPINS-1:0]      out_q, oe_q, st_q;
    logic [NPINS-1:0]      sync_w, prev_w, evt_w, od_w, wake_en_w;
    logic [NPINS-1:0][2:0] mode_w;
    pin_cfg_t              cfg_q [NPINS];

    int     addr_i;
    wr_op_e op_out, op_oe, op_st;
    word_t  out_n, oe_n, st_n;

    assign addr_i = int'(bus_addr);

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst(rst), .pad_i(pad_in), .sync_o(sync_w), .prev_o(prev_w)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_cfg
        assign od_w[n]      = cfg_q[n].od;
        assign mode_w[n]    = cfg_q[n].mode;
        assign wake_en_w[n] = cfg_q[n].wake;
    end

    gpio_evt_detect #(.W(NPINS)) u_evt (
        .mode_i(mode_w), .cur_i(sync_w), .prv_i(prev_w), .evt_o(evt_w)
    );

    gpio_pad_drive #(.W(NPINS)) u_drive (
        .od_i(od_w), .data_i(out_q), .oe_i(oe_q), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
    );

    // next-state of the three aliased registers, in bus bit positions
    always_comb begin
        op_out = decode_op(addr_i, A_OUT, bus_we);
        op_oe  = decode_op(addr_i, A_OE,  bus_we);
        op_st  = decode_op(addr_i, A_ST,  bus_we);
        out_n  = apply_op(op_out, BUS_W'(out_q) << PIN_LSB, bus_wdata);
        oe_n   = apply_op(op_oe,  BUS_W'(oe_q)  << PIN_LSB, bus_wdata);
        st_n   = apply_op(op_st,  BUS_W'(st_q)  << PIN_LSB, bus_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            oe_q  <= '0;
            st_q  <= '0;
            for (int n = 0; n < NPINS; n++) cfg_q[n] <= '0;
        end else begin
            out_q <= out_n[PIN_LSB +: NPINS];
            oe_q  <= oe_n[PIN_LSB +: NPINS];
            // hardware hits are ORed after the software op, so they win
            st_q  <= st_n[PIN_LSB +: NPINS] | evt_w;
            for (int n = 0; n < NPINS; n++) begin
                if (bus_we && addr_i == A_CFG0 + 4*n) cfg_q[n] <= cfg_unpack(bus_wdata);
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_i == A_OUT)      bus_rdata = BUS_W'(out_q)  << PIN_LSB;
        else if (addr_i == A_OE)  bus_rdata = BUS_W'(oe_q)   << PIN_LSB;
        else if (addr_i == A_ST)  bus_rdata = BUS_W'(st_q)   << PIN_LSB;
        else if (addr_i == A_IN)  bus_rdata = BUS_W'(sync_w) << PIN_LSB;
        for (int n = 0; n < NPINS; n++) begin
            if (addr_i == A_CFG0 + 4*n) bus_rdata = cfg_pack(cfg_q[n]);
        end
    end

    assign irq  = |st_q;
    assign wake = |(st_q & wake_en_w);

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (st_q == '0 && pad_oe == '0 && !irq && !wake));

    // R6
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ((st_q & $past(st_q)) == $past(st_q)));

    // R9
    hit_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_w) |=> irq);

    // R10
    wake_implies_irq_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> irq);

    for (genvar n = 0; n < NPINS; n++) begin : g_drive_chk
        // R11
        od_release_chk: assert property (@(posedge clk) disable iff (rst)
            (od_w[n] && (out_q[n] || !oe_q[n])) |-> (!pad_oe[n] && !pad_out[n]));
        // R11
        pp_follow_chk: assert property (@(posedge clk) disable iff (rst)
            !od_w[n] |-> (pad_oe[n] == oe_q[n] && pad_out[n] == out_q[n]));
    end
endmodule

// File: tb/test_sc_gpio_bank.sv
module test_sc_gpio_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [21:0] pad_in = '0;
    logic [21:0] pad_out, pad_oe;
    logic        irq, wake;

    int checks = 0;
    int fails  = 0;

    localparam logic [7:0] OUT = 8'h00, OUT_S = 8'h04, OUT_C = 8'h08;
    localparam logic [7:0] OE  = 8'h0C, OE_S  = 8'h10, OE_C  = 8'h14;
    localparam logic [7:0] ST  = 8'h18, ST_S  = 8'h1C, ST_C  = 8'h20;
    localparam logic [7:0] INP = 8'h24;

    always #4 clk = ~clk;

    sc_gpio_bank i_sc_gpio_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .wake(wake)
    );

    function automatic logic [7:0] cfga(int n);
        return 8'(8'h28 + 4*n);
    endfunction

    function automatic logic [31:0] cfgw(logic od, logic [2:0] mode, logic wk);
        return (32'(wk) << 10) | (32'(mode) << 7) | (32'(od) << 2);
    endfunction

    function automatic logic [31:0] pb(int n);
        return 32'h1 << (10 + n);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(OUT, d); chk("R1 out", d, 0);
        rd(OE, d);  chk("R1 oe", d, 0);
        rd(ST, d);  chk("R1 status", d, 0);
        rd(cfga(0), d); chk("R1 cfg", d, 0);
        chk("R1 pad_oe", 32'(pad_oe), 0);
        chk("R1 irq/wake", {30'b0, irq, wake}, 0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        wr(OUT, 32'hFFFF_FFFF);
        rd(OUT, d); chk("R2 low bits zero", d, 32'hFFFF_FC00);
        chk("R2 pad_out all", 32'(pad_out), 32'h3F_FFFF);
        wr(OUT, 32'h0000_03FF);
        rd(OUT, d); chk("R2 low bits ignored", d, 0);
        rd(OUT_S, d); chk("R2 alias reads zero", d, 0);
        rd(8'hF0, d); chk("R2 unmapped reads zero", d, 0);
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        wr(OUT_S, pb(2) | pb(21));
        rd(OUT, d); chk("R3 out set", d, 32'h8000_1000);
        wr(OUT_C, pb(21));
        rd(OUT, d); chk("R3 out clr", d, 32'h0000_1000);
        wr(OUT, pb(10));
        rd(OUT, d); chk("R3 out overwrite", d, 32'h0010_0000);
        wr(OE_S, 32'hFFFF_FC00);
        wr(OE_C, 32'h5555_5400);
        rd(OE, d); chk("R3 oe set/clr", d, 32'hAAAA_A800);
        chk("R3 pad_oe", 32'(pad_oe), 32'h2A_AAAA);
        wr(OE, 0); wr(OUT, 0);
    endtask

    task automatic t_input();
        logic [31:0] d;
        pad_in = 22'h0;
        settle();
        @(negedge clk);
        pad_in = 22'h2A5A5;
        #1 chk("R5 before any edge", bus_rdata_at(INP), 0);
        @(negedge clk);
        #1 chk("R5 after one edge", bus_rdata_at(INP), 0);
        @(negedge clk);
        #1 chk("R5 after two edges", bus_rdata_at(INP), 32'(22'h2A5A5) << 10);
        pad_in = 22'h0;
        settle();
        rd(INP, d); chk("R5 back to zero", d, 0);
    endtask

    function automatic logic [31:0] bus_rdata_at(logic [7:0] a);
        bus_addr = a;
        return bus_rdata;
    endfunction

    task automatic t_edge();
        logic [31:0] d;
        wr(cfga(3), cfgw(0, 3'd1, 0));
        wr(cfga(4), cfgw(0, 3'd2, 0));
        wr(cfga(5), cfgw(0, 3'd3, 0));
        wr(ST, 0);
        @(negedge clk); pad_in[5:3] = 3'b111;
        settle();
        rd(ST, d); chk("R6 rising", d, pb(3) | pb(5));
        wr(ST_C, 32'hFFFF_FFFF);
        @(negedge clk); pad_in[5:3] = 3'b000;
        settle();
        rd(ST, d); chk("R6 falling", d, pb(4) | pb(5));
        settle();
        rd(ST, d); chk("R6 sticky", d, pb(4) | pb(5));
        wr(ST_C, 32'hFFFF_FFFF);
        rd(ST, d); chk("R6 ack", d, 0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(cfga(6), cfgw(0, 3'd5, 0));
        wr(cfga(7), cfgw(0, 3'd4, 0));
        settle();
        rd(ST, d); chk("R7 low level", d, pb(7));
        wr(ST_C, pb(7));
        rd(ST, d); chk("R7 clear while low", d, pb(7));
        @(negedge clk); pad_in[6] = 1'b1;
        settle();
        rd(ST, d); chk("R7 high level", d, pb(6) | pb(7));
        @(negedge clk); pad_in[6] = 1'b0; pad_in[7] = 1'b1;
        settle();
        wr(ST_C, 32'hFFFF_FFFF);
        rd(ST, d); chk("R7 clear after level gone", d, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        wr(cfga(9), cfgw(0, 3'd6, 0));
        wr(cfga(10), cfgw(0, 3'd7, 0));
        @(negedge clk); pad_in[10:8] = 3'b111;
        settle();
        rd(ST, d); chk("R8 disabled high", d, 0);
        @(negedge clk); pad_in[10:8] = 3'b000;
        settle();
        rd(ST, d); chk("R8 disabled low", d, 0);
        chk("R8 irq", 32'(irq), 0);
    endtask

    task automatic t_force();
        logic [31:0] d;
        wr(ST_S, pb(11));
        rd(ST, d); chk("R4 forced", d, pb(11));
        chk("R4 irq on force", 32'(irq), 1);
        wr(ST_C, pb(11));
        rd(ST, d); chk("R4 ack", d, 0);
        chk("R4 irq off", 32'(irq), 0);
        wr(ST, 32'h0000_0C00);
        rd(ST, d); chk("R4 overwrite", d, 32'h0000_0C00);
        wr(ST, 0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr(cfga(12), cfgw(0, 3'd1, 0));
        wr(ST, 0);
        @(negedge clk); pad_in[12] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = ST_C; bus_wdata = pb(12); bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(ST, d); chk("R9 set beats clear", d, pb(12));
        wr(ST_C, pb(12));
        rd(ST, d); chk("R9 later clear", d, 0);
    endtask

    task automatic t_irq_wake();
        logic [31:0] d;
        wr(cfga(13), cfgw(0, 3'd1, 1));
        wr(cfga(14), cfgw(0, 3'd1, 0));
        @(negedge clk); pad_in[14] = 1'b1;
        settle();
        chk("R10 irq no wake", {30'b0, irq, wake}, 32'h2);
        @(negedge clk); pad_in[13] = 1'b1;
        settle();
        chk("R10 irq and wake", {30'b0, irq, wake}, 32'h3);
        wr(ST_C, pb(13));
        chk("R10 wake drops", {30'b0, irq, wake}, 32'h2);
        wr(ST_C, pb(14));
        rd(ST, d);
        chk("R10 all clear", {d[31:2], irq, wake}, 0);
    endtask

    task automatic t_opendrain();
        wr(cfga(15), cfgw(1, 3'd0, 0));
        wr(OUT_S, pb(15) | pb(16));
        wr(OE_S, pb(15) | pb(16));
        chk("R11 od high releases", {30'b0, pad_oe[15], pad_out[15]}, 0);
        chk("R11 pp high", {30'b0, pad_oe[16], pad_out[16]}, 32'h3);
        wr(OUT_C, pb(15) | pb(16));
        chk("R11 od low drives", {30'b0, pad_oe[15], pad_out[15]}, 32'h2);
        chk("R11 pp low", {30'b0, pad_oe[16], pad_out[16]}, 32'h2);
        wr(OE_C, pb(15) | pb(16));
        chk("R11 disabled", {30'b0, pad_oe[15], pad_oe[16]}, 0);
    endtask

    task automatic t_cfgread();
        logic [31:0] d;
        wr(cfga(17), 32'hFFFF_FFFF);
        rd(cfga(17), d); chk("R12 fields only", d, 32'h0000_0784);
        wr(cfga(21), 32'h0000_0284);
        rd(cfga(21), d); chk("R12 last pin", d, 32'h0000_0284);
        wr(cfga(21), 0);
        rd(cfga(21), d); chk("R12 cleared", d, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_reset();
        t_layout();
        t_setclr();
        t_input();
        t_edge();
        t_level();
        t_disabled();
        t_force();
        t_race();
        t_irq_wake();
        t_opendrain();
        t_cfgread();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule